// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single down-counter that software drives through a small word-indexed register window. A write strobe, a read strobe, a 3-bit word index and a 32-bit data bus reach the configuration, the reload values, the live count and the interrupt status. Register access is a plain single-cycle strobe interface with no valid/ready flow control. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational and valid in the same cycle as `rd_en`, so there is no back-pressure on either side. One level-sensitive interrupt line leaves the block.

The counter steps down once per prescaled tick. It can run in three modes:

- **Periodic:** the count returns to a stored reload value.
- **Free-running:** the count wraps to all-ones of the selected width.
- **One-shot:** the count parks at zero.

There are two ways to set the reload value. One write path restarts the count at once. The other path changes only the value used at the next reload.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset the configuration word (index 2) reads 0x20, with only the interrupt-enable bit set. The count (index 1) reads 0x0000FFFF. Both status words read 0 and `irq` is low.
- R2: A write to index 0 stores the reload value and puts the written value into the counter at that clock edge. Reading index 0 returns the stored reload value.
- R3: A write to index 6 changes only the stored reload value and leaves the running count untouched. The new value is loaded at the next reload.
- R4: Configuration bit 7 starts counting. With bit 7 clear the count holds its present value, and setting bit 7 again resumes from that value.
- R5: With configuration bit 6 set (periodic) and bit 0 clear, the first tick that finds the count at zero reloads the stored reload value.
- R6: With bits 6 and 0 both clear (free-running), the first tick that finds the count at zero loads 0xFFFF when bit 1 is clear, or 0xFFFFFFFF when bit 1 is set.
- R7: With configuration bit 0 set (one-shot), the count stays at zero once it arrives there. No further expiry follows.
- R8: With configuration bit 1 clear (16-bit size), only the low 16 counter bits are decremented and tested for zero, and index 1 reads the upper 16 bits as zero.
- R9: Configuration bits [3:2] select the tick rate. Code 00 and code 11 tick every cycle, code 01 ticks every 16th cycle and code 10 ticks every 256th cycle. A write to index 0 or index 2 restarts the prescale phase, so the first tick comes 1, 16 or 256 cycles after that write.
- R10: A tick that moves the count from 1 to 0 is an expiry and sets the raw flag, read as bit 0 of index 4. Any write to index 3 clears the flag. If an expiry and a clear fall in the same cycle, the flag stays set.
- R11: `irq` equals the raw flag ANDed with configuration bit 5. Index 5 reads that same masked value, so it reads 0 whenever bit 5 is clear.
- R12: A write to index 1 has no effect. A read of index 7 returns 0, and `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word index of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, zero when `rd_en` is low |
| irq | output | 1 | Level interrupt (raw flag AND enable bit) |

## Verification
The hardest case to reach from the ports is an interrupt clear that arrives in the very cycle the count goes from 1 to 0. The bench loads 2 in periodic mode at divide-by-1 and starts the counter. It then waits exactly one cycle and issues the clear write so that the clear's clock edge is the expiry edge. The prescaler phase is the other hard case. Because control and load writes restart the phase, the bench can check that the count is unchanged one cycle before the 16th and 256th cycle and has stepped on that cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;
  localparam int CFG_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD_NOW   = 3'd0,
    REG_COUNT        = 3'd1,
    REG_CFG          = 3'd2,
    REG_ACK          = 3'd3,
    REG_RAW          = 3'd4,
    REG_MASKED       = 3'd5,
    REG_RELOAD_LATER = 3'd6,
    REG_NONE         = 3'd7
  } reg_addr_e;

  // Configuration word, MSB first
  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] pre;       // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } cfg_t;

  localparam logic [CFG_W-1:0] CFG_RESET = 8'h20;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              load_now,
  output logic              cfg_wr,
  output logic              ack
);

  reg_addr_e sel;
  logic      reload_wr;

  always_comb begin
    sel       = reg_addr_e'(addr);
    load_now  = wr_en && (sel == REG_RELOAD_NOW);
    cfg_wr    = wr_en && (sel == REG_CFG);
    ack       = wr_en && (sel == REG_ACK);
    reload_wr = load_now || (wr_en && (sel == REG_RELOAD_LATER));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= cfg_t'(CFG_RESET);
      reload_q <= '0;
    end else begin
      if (cfg_wr)    cfg_q    <= cfg_t'(wr_data[CFG_W-1:0]);
      if (reload_wr) reload_q <= wr_data;
    end
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [SHIFT_HI-1:0] pre_q;
  logic                at_end;

  always_comb begin
    unique case (sel)
      2'b01:   at_end = &pre_q[SHIFT_MID-1:0];
      2'b10:   at_end = &pre_q;
      default: at_end = 1'b1;
    endcase
    tick = run && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             oneshot,
  input  logic             periodic,
  input  logic             wide,
  output logic [CNT_W-1:0] count_eff,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec_val, fill_val;
  logic             at_zero;

  generate
    if (CNT_W > NARROW_W) begin : g_split
      localparam int UP_W = CNT_W - NARROW_W;
      logic [UP_W-1:0]     upper;
      logic [NARROW_W-1:0] lower;
      assign upper = cnt_q[CNT_W-1:NARROW_W];
      assign lower = cnt_q[NARROW_W-1:0];
      always_comb begin
        if (wide) begin
          count_eff = cnt_q;
          dec_val   = cnt_q - 1'b1;
          fill_val  = '1;
        end else begin
          count_eff = {{UP_W{1'b0}}, lower};
          dec_val   = {upper, lower - 1'b1};
          fill_val  = {upper, {NARROW_W{1'b1}}};
        end
      end
    end else begin : g_flat
      always_comb begin
        count_eff = cnt_q;
        dec_val   = cnt_q - 1'b1;
        fill_val  = '1;
      end
    end
  endgenerate

  always_comb begin
    at_zero = (count_eff == '0);
    expire  = tick && !load_now && (count_eff == CNT_W'(1));
    cnt_d   = cnt_q;
    if (load_now) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (!at_zero)      cnt_d = dec_val;
      else if (!oneshot) cnt_d = periodic ? reload_val : fill_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  input  logic ie,
  output logic raw_q,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (expire) raw_q <= 1'b1;
    else if (ack)    raw_q <= 1'b0;
  end

  assign irq = raw_q && ie;

endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 16,
  parameter int PRE_MID   = 4,
  parameter int PRE_HI    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  cfg_t              cfg_q;
  logic [DATA_W-1:0] reload_q;
  logic              load_now, cfg_wr, ack;
  logic              tick, expire, raw_q;
  logic [DATA_W-1:0] count_eff;
  logic [DATA_W-1:0] rd_mux;

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .cfg_q    (cfg_q),
    .reload_q (reload_q),
    .load_now (load_now),
    .cfg_wr   (cfg_wr),
    .ack      (ack)
  );

  tmr_prescale #(.SHIFT_MID(PRE_MID), .SHIFT_HI(PRE_HI)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_q.run),
    .restart (cfg_wr || load_now),
    .sel     (cfg_q.pre),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_now   (load_now),
    .load_val   (wr_data),
    .reload_val (reload_q),
    .oneshot    (cfg_q.oneshot),
    .periodic   (cfg_q.periodic),
    .wide       (cfg_q.wide),
    .count_eff  (count_eff),
    .expire     (expire)
  );

  tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .ack    (ack),
    .ie     (cfg_q.ie),
    .raw_q  (raw_q),
    .irq    (irq)
  );

  always_comb begin
    unique case (reg_addr_e'(addr))
      REG_RELOAD_NOW,
      REG_RELOAD_LATER: rd_mux = reload_q;
      REG_COUNT:        rd_mux = count_eff;
      REG_CFG:          rd_mux = DATA_W'(cfg_q);
      REG_RAW:          rd_mux = DATA_W'(raw_q);
      REG_MASKED:       rd_mux = DATA_W'(irq);
      default:          rd_mux = '0;
    endcase
    rd_data = rd_en ? rd_mux : '0;
  end

endmodule

// File: rtl/tmr_down_timer_chk.sv
module tmr_down_timer_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [7:0]        cfg,
  input logic [DATA_W-1:0] cnt_eff,
  input logic              raw,
  input logic              expire,
  input logic              tick,
  input logic              irq
);

  logic [DATA_W-1:0] width_mask;
  assign width_mask = cfg[1] ? {DATA_W{1'b1}} : DATA_W'({NARROW_W{1'b1}});

  // R2: immediate load lands in the count on the next cycle
  p_load_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (cnt_eff == ($past(wr_data) & width_mask)));

  // R3: deferred load does not disturb the count when no tick occurs
  p_bgload_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6 && !tick) |=> $stable(cnt_eff));

  // R4: stopped counter holds
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[7] && !(wr_en && (addr == 3'd0 || addr == 3'd2))) |=> $stable(cnt_eff));

  // R7: one-shot stays parked at zero
  p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && cnt_eff == '0 && !(wr_en && (addr == 3'd0 || addr == 3'd2)))
      |=> (cnt_eff == '0));

  // R10: expiry sets the raw flag, even against a clear
  p_raw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw);

  // R10: a clear without expiry empties the flag
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !expire) |=> !raw);

  // R11: no interrupt while masked
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[5] |-> !irq);

endmodule

bind tmr_down_timer tmr_down_timer_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .cfg     (cfg_q),
  .cnt_eff (count_eff),
  .raw     (raw_q),
  .expire  (expire),
  .tick    (tick),
  .irq     (irq)
);

// File: tb/tb_tmr_down_timer.sv
module tb_tmr_down_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tmr_down_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); chk("R1 cfg", v, 32'h20);
    rd(3'd1, v); chk("R1 count", v, 32'h0000FFFF);
    rd(3'd4, v); chk("R1 raw", v, 0);
    rd(3'd5, v); chk("R1 masked", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R12 idle rd_data", rd_data, 0);
  endtask

  task automatic t_ignored_and_load();
    logic [31:0] v;
    wr(3'd1, 32'h1234);
    rd(3'd1, v); chk("R12 count write ignored", v, 32'h0000FFFF);
    rd(3'd7, v); chk("R12 index 7 reads zero", v, 0);
    wr(3'd0, 32'd5);
    rd(3'd1, v); chk("R2 immediate load", v, 32'd5);
    rd(3'd0, v); chk("R2 reload readback", v, 32'd5);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(3'd2, 32'hE2);
    rd(3'd1, v); chk("R5 start", v, 32'd5);
    idle(4); rd(3'd1, v); chk("R5 count", v, 32'd1);
    idle(1); rd(3'd1, v); chk("R5 zero", v, 32'd0);
    rd(3'd4, v); chk("R10 raw set", v, 1);
    chk("R11 irq high", {31'b0, irq}, 1);
    idle(1); rd(3'd1, v); chk("R5 reload", v, 32'd5);
    wr(3'd3, 32'h0);
    rd(3'd4, v); chk("R10 clear", v, 0);
    chk("R11 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_freeze_bgload();
    logic [31:0] v, held;
    wr(3'd2, 32'h62);
    rd(3'd1, held);
    idle(10); rd(3'd1, v); chk("R4 frozen", v, held);
    wr(3'd6, 32'd9);
    rd(3'd1, v); chk("R3 count untouched", v, held);
    wr(3'd2, 32'hE2);
    rd(3'd1, v); chk("R4 resume value", v, held);
    idle(int'(held)); rd(3'd1, v); chk("R4 resumed to zero", v, 0);
    idle(1); rd(3'd1, v); chk("R3 deferred reload", v, 32'd9);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(3'd2, 32'h62);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hE2);
    idle(1);
    wr(3'd3, 32'h0);
    rd(3'd4, v); chk("R10 expiry beats clear", v, 1);
  endtask

  task automatic t_free32();
    logic [31:0] v;
    wr(3'd2, 32'h22);
    wr(3'd0, 32'd2);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hA2);
    idle(2); rd(3'd1, v); chk("R6 zero 32", v, 0);
    idle(1); rd(3'd1, v); chk("R6 wrap 32", v, 32'hFFFFFFFF);
  endtask

  task automatic t_free16();
    logic [31:0] v;
    wr(3'd2, 32'h20);
    wr(3'd0, 32'hABCD0002);
    rd(3'd1, v); chk("R8 upper hidden", v, 32'h2);
    wr(3'd2, 32'hA0);
    idle(2); rd(3'd1, v); chk("R8 zero 16", v, 0);
    idle(1); rd(3'd1, v); chk("R6 wrap 16", v, 32'h0000FFFF);
    idle(1); rd(3'd1, v); chk("R8 step 16", v, 32'h0000FFFE);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(3'd2, 32'h23);
    wr(3'd0, 32'd3);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hA3);
    idle(3); rd(3'd1, v); chk("R7 reach zero", v, 0);
    rd(3'd4, v); chk("R7 expiry flag", v, 1);
    wr(3'd3, 32'h0);
    idle(5);
    rd(3'd1, v); chk("R7 parked", v, 0);
    rd(3'd4, v); chk("R7 no second expiry", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(3'd2, 32'h42);
    wr(3'd0, 32'd1);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hC2);
    idle(1);
    rd(3'd4, v); chk("R11 raw while masked", v, 1);
    rd(3'd5, v); chk("R11 masked reads zero", v, 0);
    chk("R11 irq masked", {31'b0, irq}, 0);
    wr(3'd2, 32'hE2);
    rd(3'd5, v); chk("R11 masked after enable", v, 1);
    chk("R11 irq after enable", {31'b0, irq}, 1);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(3'd2, 32'h22);
    wr(3'd0, 32'd100);
    wr(3'd2, 32'h86);
    idle(15); rd(3'd1, v); chk("R9 div16 before", v, 32'd100);
    idle(1);  rd(3'd1, v); chk("R9 div16 step", v, 32'd99);
    wr(3'd2, 32'h2A);
    wr(3'd0, 32'd100);
    wr(3'd2, 32'h8A);
    idle(255); rd(3'd1, v); chk("R9 div256 before", v, 32'd100);
    idle(1);   rd(3'd1, v); chk("R9 div256 step", v, 32'd99);
    wr(3'd2, 32'h2E);
    wr(3'd0, 32'd7);
    wr(3'd2, 32'h8E);
    idle(1); rd(3'd1, v); chk("R9 code 11 every cycle", v, 32'd6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1-all actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ignored_and_load();
    t_periodic();
    t_freeze_bgload();
    t_same_cycle();
    t_free32();
    t_free16();
    t_oneshot();
    t_mask();
    t_prescale();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule